// File: doc/BRIEF.md
# Eight-bit arithmetic unit with status flags

This block is the data path of a small eight-bit processor core. It takes two operands (a destination value and a source value, where the source is either a register or an immediate chosen by the caller), an operation code and an execute strobe. It returns the eight-bit result at once, without a clock. It also says whether that result is to be written back to the destination. On the clock edge of an executed operation, it commits the new status flags to an internal eight-bit status register.

Each operation changes only the flags it owns and leaves the others as they were. Carry-chained subtract and compare keep the zero flag once it has been cleared, so multi-byte comparisons can be built from a sequence of byte operations. A flag tester compares one selected status bit against a wanted value. The core uses it for conditional branches: signed branches test the sign flag (negative XOR overflow), and unsigned branches test carry. The tester always reads the committed status register, so during the cycle of an executed operation it still reports the flags from before that operation.

Immediate forms of the instructions use the same codes as their register forms. The caller places the constant on the source operand.

Top module: `alu8_top`

## Requirements
- R1: After reset the status register reads 0x00. Its bit order from bit 7 down to bit 0 is interrupt-enable I, transfer T, half-carry H, sign S, overflow V, negative N, zero Z, carry C.
- R2: Operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 negate, 7 and, 8 or, 9 exclusive-or, 10 complement, 11 increment, 12 decrement, 13 shift left, 14 shift right, 15 rotate left through carry, 16 rotate right through carry, 17 arithmetic shift right, 18 nibble swap, 19 set status bit, 20 clear status bit. Add and add-with-carry return (a+b+cin) mod 256, where cin is 0 for add and the committed C for add-with-carry. They set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, and N and Z from the result.
- R3: Subtract, compare and negate form a-b-bin, where bin is the committed C for the carry forms and 0 otherwise. Negate uses 0-a. C is the borrow out of bit 7, H is the borrow out of bit 3, V is signed overflow, and N and Z come from the result.
- R4: For subtract-with-carry and compare-with-carry, Z becomes 1 only when the result is zero and Z was already 1. A nonzero result clears Z.
- R5: And, or and exclusive-or clear V and set N and Z from the result. Complement returns 255-a, clears V and sets C to 1. None of these four operations changes H. The three bitwise operations also leave C unchanged.
- R6: Increment and decrement update N and Z. V is set only when increment wraps from 0x7F to 0x80 or decrement wraps from 0x80 to 0x7F. C and H are unchanged.
- R7: The shift operations are as follows. Shift left inserts 0 at bit 0. Shift right inserts 0 at bit 7. The rotates insert the committed C. Arithmetic shift right keeps bit 7. C takes the bit shifted out, and V becomes N XOR C after the shift. H is unchanged.
- R8: Nibble swap exchanges bits 7:4 with bits 3:0 and leaves every flag unchanged.
- R9: Set-bit and clear-bit force the status bit indexed by b[2:0] to 1 or 0 and change no other bit.
- R10: Every operation that updates N or V leaves S equal to N XOR V.
- R11: With the execute strobe low, the status register holds its value over the clock edge.
- R12: The branch output is high exactly when the committed status bit selected by the 3-bit flag selector equals the wanted value.
- R13: The write-back output is low for compare, compare-with-carry, set-bit and clear-bit, and high for every other operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Commit the flags of this operation at the clock edge |
| op_i | input | 5 | Operation code (R2) |
| a_i | input | 8 | Destination operand |
| b_i | input | 8 | Source operand or immediate; bit index for set/clear |
| flag_sel_i | input | 3 | Status bit tested by the branch output |
| flag_want_i | input | 1 | Value the tested bit must have |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result is to be written to the destination |
| sreg_o | output | 8 | Committed status register |
| br_taken_o | output | 1 | Branch condition met |

## Verification
The flag tester and a flag update can fall in the same cycle. While an executed operation is on the inputs, the branch output must still reflect the status register from before it, and the new flags must appear only after the edge. The sweep drives a branch query alongside every operation, chosen from the operand bits. It judges that query against the bench's model of the flags before the operation, then checks the committed register on the following cycle against the updated model. Carry-in and sticky zero come from the flags left by the previous vector, so chained operations are exercised with both polarities.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_NEG  = 5'd6,  OP_AND  = 5'd7,
        OP_OR   = 5'd8,  OP_EOR  = 5'd9,  OP_COM  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
        OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18, OP_BSET = 5'd19,
        OP_BCLR = 5'd20
    } alu_op_e;

    localparam int SR_W = 8;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
endpackage

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SR_W-1:0]  sr,
    output logic [W-1:0]     res,
    output logic [SR_W-1:0]  sr_nx,
    output logic             wr
);
    localparam int HB  = W / 2;
    localparam int MSB = W - 1;

    logic         cin, bin;
    logic [W:0]   add_w, sub_w;
    logic [HB:0]  add_h, sub_h;
    logic [W-1:0] sx, sy;

    always_comb begin
        cin   = (op == OP_ADC) ? sr[FL_C] : 1'b0;
        add_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        add_h = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
        sx    = (op == OP_NEG) ? '0 : a;
        sy    = (op == OP_NEG) ? a : b;
        bin   = (op == OP_SBC || op == OP_CPC) ? sr[FL_C] : 1'b0;
        sub_w = {1'b0, sx} - {1'b0, sy} - {{W{1'b0}}, bin};
        sub_h = {1'b0, sx[HB-1:0]} - {1'b0, sy[HB-1:0]} - {{HB{1'b0}}, bin};
    end

    logic c_n, h_n, v_n, n_n, z_n;
    logic upd_c, upd_h, upd_nzv, z_sticky;

    always_comb begin
        res      = a;
        wr       = 1'b1;
        c_n      = sr[FL_C];
        h_n      = sr[FL_H];
        v_n      = 1'b0;
        upd_c    = 1'b0;
        upd_h    = 1'b0;
        upd_nzv  = 1'b0;
        z_sticky = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res = add_w[W-1:0];
                c_n = add_w[W];
                h_n = add_h[HB];
                v_n = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
                upd_c = 1'b1; upd_h = 1'b1; upd_nzv = 1'b1;
            end
            OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                res = sub_w[W-1:0];
                c_n = sub_w[W];
                h_n = sub_h[HB];
                v_n = (sx[MSB] != sy[MSB]) && (res[MSB] != sx[MSB]);
                upd_c = 1'b1; upd_h = 1'b1; upd_nzv = 1'b1;
                z_sticky = (op == OP_SBC) || (op == OP_CPC);
                wr = !((op == OP_CP) || (op == OP_CPC));
            end
            OP_AND: begin res = a & b; upd_nzv = 1'b1; end
            OP_OR:  begin res = a | b; upd_nzv = 1'b1; end
            OP_EOR: begin res = a ^ b; upd_nzv = 1'b1; end
            OP_COM: begin
                res = ~a; c_n = 1'b1; upd_c = 1'b1; upd_nzv = 1'b1;
            end
            OP_INC: begin
                res = a + 1'b1;
                v_n = (a == {1'b0, {MSB{1'b1}}});
                upd_nzv = 1'b1;
            end
            OP_DEC: begin
                res = a - 1'b1;
                v_n = (a == {1'b1, {MSB{1'b0}}});
                upd_nzv = 1'b1;
            end
            OP_LSL, OP_ROL: begin
                res = {a[MSB-1:0], (op == OP_ROL) ? sr[FL_C] : 1'b0};
                c_n = a[MSB];
                v_n = res[MSB] ^ a[MSB];
                upd_c = 1'b1; upd_nzv = 1'b1;
            end
            OP_LSR, OP_ROR, OP_ASR: begin
                if (op == OP_ROR)      res = {sr[FL_C], a[MSB:1]};
                else if (op == OP_ASR) res = {a[MSB], a[MSB:1]};
                else                   res = {1'b0, a[MSB:1]};
                c_n = a[0];
                v_n = res[MSB] ^ a[0];
                upd_c = 1'b1; upd_nzv = 1'b1;
            end
            OP_SWAP: res = {a[HB-1:0], a[W-1:HB]};
            OP_BSET, OP_BCLR: wr = 1'b0;
            default: res = a;
        endcase
    end

    always_comb begin
        n_n = res[MSB];
        z_n = (res == '0) && (!z_sticky || sr[FL_Z]);
        sr_nx = sr;
        if (upd_c) sr_nx[FL_C] = c_n;
        if (upd_h) sr_nx[FL_H] = h_n;
        if (upd_nzv) begin
            sr_nx[FL_N] = n_n;
            sr_nx[FL_Z] = z_n;
            sr_nx[FL_V] = v_n;
            sr_nx[FL_S] = n_n ^ v_n;
        end
        if (op == OP_BSET) sr_nx[b[2:0]] = 1'b1;
        if (op == OP_BCLR) sr_nx[b[2:0]] = 1'b0;
    end
endmodule

// File: rtl/alu8_sreg.sv
module alu8_sreg
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SR_W-1:0]  d,
    output logic [SR_W-1:0]  q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/alu8_flagtest.sv
module alu8_flagtest
    import alu8_pkg::*;
(
    input  logic [SR_W-1:0]          sr,
    input  logic [$clog2(SR_W)-1:0]  sel,
    input  logic                     want,
    output logic                     hit
);
    always_comb hit = (sr[sel] == want);
endmodule

// File: rtl/alu8_top.sv
module alu8_top
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [2:0]    flag_sel_i,
    input  logic          flag_want_i,
    output logic [W-1:0]  result_o,
    output logic          wr_en_o,
    output logic [7:0]    sreg_o,
    output logic          br_taken_o
);
    alu_op_e          op;
    logic [SR_W-1:0]  sr_nx;

    assign op = alu_op_e'(op_i);

    alu8_core #(.W(W)) u_core (
        .op    (op),
        .a     (a_i),
        .b     (b_i),
        .sr    (sreg_o),
        .res   (result_o),
        .sr_nx (sr_nx),
        .wr    (wr_en_o)
    );

    alu8_sreg u_sreg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (exec_i),
        .d     (sr_nx),
        .q     (sreg_o)
    );

    alu8_flagtest u_test (
        .sr   (sreg_o),
        .sel  (flag_sel_i),
        .want (flag_want_i),
        .hit  (br_taken_o)
    );
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        exec_i,
    input alu_op_e     op,
    input logic [7:0]  sreg_o
);
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(sreg_o));

    assert_sign_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && op != OP_SWAP && op != OP_BSET && op != OP_BCLR
        |=> sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V]));

    assert_swap_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && op == OP_SWAP |=> $stable(sreg_o));

    assert_com_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && op == OP_COM |=> sreg_o[FL_C]);

    assert_logic_clears_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && (op == OP_AND || op == OP_OR || op == OP_EOR) |=> !sreg_o[FL_V]);

    assert_sticky_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && (op == OP_CPC || op == OP_SBC) && !sreg_o[FL_Z] |=> !sreg_o[FL_Z]);
endmodule

bind alu8_top alu8_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec_i (exec_i),
    .op     (op),
    .sreg_o (sreg_o)
);

// File: tb/sim_alu8_top.sv
module sim_alu8_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] flag_sel_i = '0;
    logic       flag_want_i = 1'b0;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic [7:0] sreg_o;
    logic       br_taken_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_top u0 (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .flag_sel_i(flag_sel_i), .flag_want_i(flag_want_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .sreg_o(sreg_o), .br_taken_o(br_taken_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic string tag_of(input int op);
        if (op <= 1) return "R2";
        if (op == 3 || op == 5) return "R4";
        if (op <= 6) return "R3";
        if (op <= 10) return "R5";
        if (op <= 12) return "R6";
        if (op <= 17) return "R7";
        if (op == 18) return "R8";
        return "R9";
    endfunction

    task automatic model(input int op, input int a, input int b, input logic [7:0] s,
                         output int r, output logic [7:0] ns, output bit wr, output bit touch);
        int c, t, sv, x, y, bi;
        bit v, sticky, n, z;
        c = int'(s[0]);
        ns = s; wr = 1; r = a; touch = 0; v = 0; sticky = 0;
        case (op)
            0, 1: begin
                bi = (op == 1) ? c : 0;
                t = a + b + bi; r = t & 255;
                ns[0] = (t > 255);
                ns[5] = ((a & 15) + (b & 15) + bi) > 15;
                sv = sgn(a) + sgn(b) + bi; v = (sv > 127) || (sv < -128);
                touch = 1;
            end
            2, 3, 4, 5, 6: begin
                x = (op == 6) ? 0 : a;
                y = (op == 6) ? a : b;
                bi = (op == 3 || op == 5) ? c : 0;
                t = x - y - bi; r = t & 255;
                ns[0] = (t < 0);
                ns[5] = ((x & 15) - (y & 15) - bi) < 0;
                sv = sgn(x) - sgn(y) - bi; v = (sv > 127) || (sv < -128);
                sticky = (op == 3 || op == 5);
                wr = !(op == 4 || op == 5);
                touch = 1;
            end
            7:  begin r = a & b; touch = 1; end
            8:  begin r = a | b; touch = 1; end
            9:  begin r = a ^ b; touch = 1; end
            10: begin r = 255 - a; ns[0] = 1; touch = 1; end
            11: begin r = (a + 1) & 255; v = (a == 127); touch = 1; end
            12: begin r = (a + 255) & 255; v = (a == 128); touch = 1; end
            13, 15: begin
                r = ((a * 2) & 255) + ((op == 15) ? c : 0);
                ns[0] = (a >= 128); v = (r >= 128) ^ ns[0]; touch = 1;
            end
            14, 16, 17: begin
                r = a / 2;
                if (op == 16) r = r + 128 * c;
                if (op == 17) r = r + (a & 128);
                ns[0] = (a % 2 == 1); v = (r >= 128) ^ ns[0]; touch = 1;
            end
            18: r = (a % 16) * 16 + a / 16;
            19: begin ns[b % 8] = 1'b1; wr = 0; end
            default: begin ns[b % 8] = 1'b0; wr = 0; end
        endcase
        if (touch) begin
            n = (r >= 128);
            z = (r == 0) && (!sticky || s[1]);
            ns[2] = n; ns[1] = z; ns[3] = v; ns[4] = n ^ v;
        end
    endtask

    initial begin
        logic [7:0] exp_s, ns;
        int r, prev_op;
        bit wr, touch, pend, prev_exec, prev_touch;
        int bl[8];
        pend = 0; prev_op = 0; prev_exec = 0; prev_touch = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "status after reset", int'(sreg_o), 0);
        flag_sel_i = 3'd1; flag_want_i = 1'b0; #1;
        check("R12", "branch on reset flags", int'(br_taken_o), 1);
        rst_n = 1'b1;
        exp_s = 8'h00;
        for (int op = 0; op <= 20; op++) begin
            for (int a = 0; a < 256; a++) begin
                bl[0] = 8'h00; bl[1] = 8'h01; bl[2] = 8'h7F; bl[3] = 8'h80;
                bl[4] = 8'hFF; bl[5] = a; bl[6] = (a * 37 + 11) & 255; bl[7] = a ^ 8'h55;
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    if (pend) begin
                        check(prev_exec ? tag_of(prev_op) : "R11", "status", int'(sreg_o), int'(exp_s));
                        if (prev_exec && prev_touch)
                            check("R10", "S vs N^V", int'(sreg_o[4]), int'(sreg_o[3] ^ sreg_o[2]));
                        exp_s = sreg_o;
                    end
                    exec_i = ((a + k) % 5) != 2;
                    op_i = 5'(op); a_i = 8'(a); b_i = 8'(bl[k]);
                    flag_sel_i = 3'(a[2:0] ^ k[2:0]);
                    flag_want_i = a[3];
                    model(op, a, bl[k], exp_s, r, ns, wr, touch);
                    #1;
                    check("R13", "write enable", int'(wr_en_o), int'(wr));
                    if (wr) check(tag_of(op), "result", int'(result_o), r);
                    check("R12", "branch uses old flags",
                          int'(br_taken_o), int'(exp_s[flag_sel_i] == flag_want_i));
                    prev_op = op; prev_exec = exec_i; prev_touch = touch; pend = 1;
                    if (exec_i) exp_s = ns;
                end
            end
        end
        @(negedge clk);
        check(prev_exec ? tag_of(prev_op) : "R11", "status", int'(sreg_o), int'(exp_s));
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule